// File: doc/BRIEF.md
# Trial Trim Code Counter

This block holds the temporary, power-cycle-volatile trial setting of a programmable magnetic switch while its switchpoint and output options are being tuned. A key decoder upstream tells it which trim register was selected and when the selection completed. After that, every qualified falling edge of a mid-level supply pulse advances an internal code. The block turns that code into the applied switchpoint magnitude, the field-polarity bit, the output fall-time setting and the output-polarity bit.

Four threshold registers give up-counting and down-counting access to the magnitude for either field polarity. A down-counting register inverts the code, so the magnitude runs from the top of its range downward. In a shared output register one code sets fall time and output polarity together. A fuse-check register raises requests for the intact-fuse and blown-fuse threshold tests, and this register still works after the part is locked. Fuses that are already blown force their setting bit to one whatever the trial code is. Synchronous reset models a power cycle and clears every trial value.

Top module: `trial_trim_top`

## Requirements
- R1: While reset is asserted, and after it is released with no further stimulus, every output reads zero: magnitude 0, polarity 0, fall time 0, output polarity 0, and no check or marginal flag.
- R2: A key-complete strobe loads the code with 1 and makes `reg_sel` the active register. Encoding: 0 positive up, 1 negative up, 2 positive down, 3 negative down, 4 output register, 5 fuse-check register. Values 6 and 7 select nothing.
- R3: In a threshold register each mid-pulse strobe adds 1 to the 8-bit code, and the strobe after code 255 wraps it to 0. In an up-counting register the applied magnitude equals the code.
- R4: In a down-counting register (select 2 or 3) the applied magnitude is 255 minus the code. Code 1 gives 254, code 255 gives 0 and code 0 gives 255.
- R5: Selecting a positive register (select 0 or 2) drives the field-polarity output to 0 (south). Selecting a negative register (select 1 or 3) drives it to 1 (north).
- R6: In the output register, code bits 1:0 set the fall time and code bit 2 sets the output polarity. For example, code 7 gives fall time 3 and polarity 1. Magnitude and field polarity keep their previous trial values.
- R7: In the fuse-check register, code 8 raises `chk_lo_o` (intact-fuse check) alone and code 9 raises `chk_hi_o` (blown-fuse check) alone. Every other code raises neither.
- R8: A blown fuse input forces the matching output bit to 1 regardless of the trial value. Unblown bits pass the trial value through.
- R9: While `fuse_lock` is 1, a key for any register other than the fuse-check register selects nothing, so the following mid pulses leave every setting unchanged. The fuse-check register still works.
- R10: `marg_o` is 1 exactly when a check request is raised and at least one bit of `fuse_marg` is 1.
- R11: A mid-pulse strobe while no register is selected has no effect on any output. Trial values persist across changes of the selected register until reset.
- R12: The result of a key or mid strobe appears on the outputs after the second rising edge following the edge that samples the strobe. A change on the fuse inputs appears after the first rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power cycle) |
| reg_sel | input | 3 | Register chosen by the key decoder, sampled on key_done |
| key_done | input | 1 | One-cycle strobe: final high pulse of a key has fallen |
| mid_fall | input | 1 | One-cycle strobe: a mid-level pulse has fallen |
| fuse_mag | input | MAG_W (8) | Blown state of the magnitude fuses |
| fuse_fpol | input | 1 | Blown state of the field-polarity fuse |
| fuse_fall | input | FALL_W (2) | Blown state of the fall-time fuses |
| fuse_opol | input | 1 | Blown state of the output-polarity fuse |
| fuse_lock | input | 1 | Blown state of the lock fuse |
| fuse_marg | input | FUSE_N (13) | Per-fuse marginal readings |
| mag_o | output | MAG_W (8) | Applied switchpoint magnitude |
| fpol_o | output | 1 | Field polarity (0 south, 1 north) |
| fall_o | output | FALL_W (2) | Output fall-time setting |
| opol_o | output | 1 | Output polarity |
| chk_lo_o | output | 1 | Intact-fuse threshold check request |
| chk_hi_o | output | 1 | Blown-fuse threshold check request |
| marg_o | output | 1 | Marginal fuse seen during a check |

## Verification
Any strobe moves the code and select registers on the edge that samples it, and the registered outputs follow one edge later. Fuse inputs pass through only the output register. The bench therefore drives each strobe for one cycle from a falling edge and waits one more full cycle before it samples at a falling edge. Fuse-driven results are sampled at the first falling edge after the change. A directed case samples between the two edges to confirm that the old value is still present.

// File: rtl/trim_pkg.sv
package trim_pkg;
  typedef enum logic [2:0] {
    SEL_POS_UP = 3'd0,
    SEL_NEG_UP = 3'd1,
    SEL_POS_DN = 3'd2,
    SEL_NEG_DN = 3'd3,
    SEL_OUT    = 3'd4,
    SEL_CHK    = 3'd5,
    SEL_NONE   = 3'd7
  } trim_sel_e;

  localparam int CHK_LO_CODE = 8;
  localparam int CHK_HI_CODE = 9;
endpackage

// File: rtl/trim_code_ctr.sv
module trim_code_ctr
  import trim_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_done,
  input  logic              mid_fall,
  input  logic [2:0]        reg_sel,
  input  logic              fuse_lock,
  output trim_sel_e         sel_q,
  output trim_sel_e         sel_d,
  output logic [CODE_W-1:0] code_q,
  output logic [CODE_W-1:0] code_d,
  output logic              step
);
  trim_sel_e sel_req;

  always_comb begin
    case (reg_sel)
      3'd0:    sel_req = SEL_POS_UP;
      3'd1:    sel_req = SEL_NEG_UP;
      3'd2:    sel_req = SEL_POS_DN;
      3'd3:    sel_req = SEL_NEG_DN;
      3'd4:    sel_req = SEL_OUT;
      3'd5:    sel_req = SEL_CHK;
      default: sel_req = SEL_NONE;
    endcase
    // after lock only the fuse-check register may be reached
    if (fuse_lock && sel_req != SEL_CHK) sel_req = SEL_NONE;
  end

  always_comb begin
    sel_d  = sel_q;
    code_d = code_q;
    step   = 1'b0;
    if (key_done) begin
      sel_d  = sel_req;
      code_d = CODE_W'(1);
      step   = 1'b1;
    end else if (mid_fall && sel_q != SEL_NONE) begin
      code_d = code_q + CODE_W'(1);
      step   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= SEL_NONE;
      code_q <= '0;
    end else begin
      sel_q  <= sel_d;
      code_q <= code_d;
    end
  end

  assert_key_load_R2: assert property (@(posedge clk) disable iff (rst)
    key_done |=> code_q == CODE_W'(1));

  assert_mid_step_R3: assert property (@(posedge clk) disable iff (rst)
    (mid_fall && !key_done && sel_q != SEL_NONE) |=>
      code_q == CODE_W'($past(code_q) + CODE_W'(1)));

  assert_lock_block_R9: assert property (@(posedge clk) disable iff (rst)
    (key_done && fuse_lock && reg_sel != 3'd5) |=> sel_q == SEL_NONE);

  assert_idle_mid_R11: assert property (@(posedge clk) disable iff (rst)
    (mid_fall && !key_done && sel_q == SEL_NONE) |=> $stable(code_q));
endmodule

// File: rtl/trim_field_map.sv
module trim_field_map
  import trim_pkg::*;
#(
  parameter int MAG_W  = 8,
  parameter int FALL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  trim_sel_e         sel_d,
  input  logic [MAG_W-1:0]  code_d,
  output logic [MAG_W-1:0]  trial_mag,
  output logic              trial_fpol,
  output logic [FALL_W-1:0] trial_fall,
  output logic              trial_opol
);
  localparam logic [MAG_W-1:0] MAG_MAX = {MAG_W{1'b1}};

  logic is_thr, is_down, is_neg;

  always_comb begin
    is_thr  = (sel_d == SEL_POS_UP) || (sel_d == SEL_NEG_UP) ||
              (sel_d == SEL_POS_DN) || (sel_d == SEL_NEG_DN);
    is_down = (sel_d == SEL_POS_DN) || (sel_d == SEL_NEG_DN);
    is_neg  = (sel_d == SEL_NEG_UP) || (sel_d == SEL_NEG_DN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trial_mag  <= '0;
      trial_fpol <= 1'b0;
      trial_fall <= '0;
      trial_opol <= 1'b0;
    end else if (step) begin
      if (is_thr) begin
        trial_mag  <= is_down ? (MAG_MAX - code_d) : code_d;
        trial_fpol <= is_neg;
      end else if (sel_d == SEL_OUT) begin
        trial_fall <= code_d[FALL_W-1:0];
        trial_opol <= code_d[FALL_W];
      end
    end
  end

  assert_south_pos_R5: assert property (@(posedge clk) disable iff (rst)
    (step && (sel_d == SEL_POS_UP || sel_d == SEL_POS_DN)) |=> !trial_fpol);

  assert_north_neg_R5: assert property (@(posedge clk) disable iff (rst)
    (step && (sel_d == SEL_NEG_UP || sel_d == SEL_NEG_DN)) |=> trial_fpol);
endmodule

// File: rtl/trim_fuse_merge.sv
module trim_fuse_merge
  import trim_pkg::*;
#(
  parameter int VEC_W  = 12,
  parameter int CODE_W = 8,
  parameter int FUSE_N = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VEC_W-1:0]  trial_vec,
  input  logic [VEC_W-1:0]  fuse_vec,
  input  trim_sel_e         sel_q,
  input  logic [CODE_W-1:0] code_q,
  input  logic [FUSE_N-1:0] fuse_marg,
  output logic [VEC_W-1:0]  out_vec,
  output logic              chk_lo_o,
  output logic              chk_hi_o,
  output logic              marg_o
);
  logic lo_d, hi_d;

  for (genvar b = 0; b < VEC_W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) out_vec[b] <= 1'b0;
      else     out_vec[b] <= trial_vec[b] | fuse_vec[b];
    end
  end

  always_comb begin
    lo_d = (sel_q == SEL_CHK) && (code_q == CODE_W'(CHK_LO_CODE));
    hi_d = (sel_q == SEL_CHK) && (code_q == CODE_W'(CHK_HI_CODE));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_lo_o <= 1'b0;
      chk_hi_o <= 1'b0;
      marg_o   <= 1'b0;
    end else begin
      chk_lo_o <= lo_d;
      chk_hi_o <= hi_d;
      marg_o   <= (lo_d | hi_d) & (|fuse_marg);
    end
  end

  assert_blown_forced_R8: assert property (@(posedge clk) disable iff (rst)
    (fuse_vec != '0) |=> ((out_vec & $past(fuse_vec)) == $past(fuse_vec)));

  assert_marg_gated_R10: assert property (@(posedge clk) disable iff (rst)
    marg_o |-> (chk_lo_o || chk_hi_o));

  assert_one_check_R7: assert property (@(posedge clk) disable iff (rst)
    !(chk_lo_o && chk_hi_o));
endmodule

// File: rtl/trial_trim_top.sv
module trial_trim_top
  import trim_pkg::*;
#(
  parameter int MAG_W  = 8,
  parameter int FALL_W = 2,
  parameter int FUSE_N = MAG_W + FALL_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        reg_sel,
  input  logic              key_done,
  input  logic              mid_fall,
  input  logic [MAG_W-1:0]  fuse_mag,
  input  logic              fuse_fpol,
  input  logic [FALL_W-1:0] fuse_fall,
  input  logic              fuse_opol,
  input  logic              fuse_lock,
  input  logic [FUSE_N-1:0] fuse_marg,
  output logic [MAG_W-1:0]  mag_o,
  output logic              fpol_o,
  output logic [FALL_W-1:0] fall_o,
  output logic              opol_o,
  output logic              chk_lo_o,
  output logic              chk_hi_o,
  output logic              marg_o
);
  localparam int VEC_W = MAG_W + FALL_W + 2;

  trim_sel_e          sel_q, sel_d;
  logic [MAG_W-1:0]   code_q, code_d;
  logic               step;
  logic [MAG_W-1:0]   t_mag;
  logic               t_fpol, t_opol;
  logic [FALL_W-1:0]  t_fall;
  logic [VEC_W-1:0]   out_vec;

  trim_code_ctr #(.CODE_W(MAG_W)) u_ctr (
    .clk(clk), .rst(rst), .key_done(key_done), .mid_fall(mid_fall),
    .reg_sel(reg_sel), .fuse_lock(fuse_lock),
    .sel_q(sel_q), .sel_d(sel_d), .code_q(code_q), .code_d(code_d),
    .step(step)
  );

  trim_field_map #(.MAG_W(MAG_W), .FALL_W(FALL_W)) u_map (
    .clk(clk), .rst(rst), .step(step), .sel_d(sel_d), .code_d(code_d),
    .trial_mag(t_mag), .trial_fpol(t_fpol), .trial_fall(t_fall),
    .trial_opol(t_opol)
  );

  trim_fuse_merge #(.VEC_W(VEC_W), .CODE_W(MAG_W), .FUSE_N(FUSE_N)) u_merge (
    .clk(clk), .rst(rst),
    .trial_vec({t_mag, t_fpol, t_fall, t_opol}),
    .fuse_vec({fuse_mag, fuse_fpol, fuse_fall, fuse_opol}),
    .sel_q(sel_q), .code_q(code_q), .fuse_marg(fuse_marg),
    .out_vec(out_vec), .chk_lo_o(chk_lo_o), .chk_hi_o(chk_hi_o),
    .marg_o(marg_o)
  );

  assign {mag_o, fpol_o, fall_o, opol_o} = out_vec;
endmodule

// File: tb/tb_trial_trim_top.sv
module tb_trial_trim_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] reg_sel = 3'd7;
  logic       key_done = 1'b0, mid_fall = 1'b0;
  logic [7:0] fuse_mag = '0;
  logic       fuse_fpol = 1'b0, fuse_opol = 1'b0, fuse_lock = 1'b0;
  logic [1:0] fuse_fall = '0;
  logic [12:0] fuse_marg = '0;
  logic [7:0] mag_o;
  logic       fpol_o, opol_o, chk_lo_o, chk_hi_o, marg_o;
  logic [1:0] fall_o;

  int errors = 0, checks = 0;

  trial_trim_top dut (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .key_done(key_done),
    .mid_fall(mid_fall), .fuse_mag(fuse_mag), .fuse_fpol(fuse_fpol),
    .fuse_fall(fuse_fall), .fuse_opol(fuse_opol), .fuse_lock(fuse_lock),
    .fuse_marg(fuse_marg), .mag_o(mag_o), .fpol_o(fpol_o), .fall_o(fall_o),
    .opol_o(opol_o), .chk_lo_o(chk_lo_o), .chk_hi_o(chk_hi_o), .marg_o(marg_o)
  );

  always #5 clk = ~clk;

  // row: {op(0 key,1 mid), sel[2:0], mag[7:0], fpol, fall[1:0], opol, lo, hi}
  localparam int NV = 24;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0,3'd0,8'd1,  1'b0,2'd0,1'b0,1'b0,1'b0},
    {1'b1,3'd0,8'd2,  1'b0,2'd0,1'b0,1'b0,1'b0},
    {1'b1,3'd0,8'd3,  1'b0,2'd0,1'b0,1'b0,1'b0},
    {1'b0,3'd3,8'd254,1'b1,2'd0,1'b0,1'b0,1'b0},
    {1'b1,3'd0,8'd253,1'b1,2'd0,1'b0,1'b0,1'b0},
    {1'b0,3'd4,8'd253,1'b1,2'd1,1'b0,1'b0,1'b0},
    {1'b1,3'd0,8'd253,1'b1,2'd2,1'b0,1'b0,1'b0},
    {1'b1,3'd0,8'd253,1'b1,2'd3,1'b0,1'b0,1'b0},
    {1'b1,3'd0,8'd253,1'b1,2'd0,1'b1,1'b0,1'b0},
    {1'b1,3'd0,8'd253,1'b1,2'd1,1'b1,1'b0,1'b0},
    {1'b1,3'd0,8'd253,1'b1,2'd2,1'b1,1'b0,1'b0},
    {1'b1,3'd0,8'd253,1'b1,2'd3,1'b1,1'b0,1'b0},
    {1'b0,3'd5,8'd253,1'b1,2'd3,1'b1,1'b0,1'b0},
    {1'b1,3'd0,8'd253,1'b1,2'd3,1'b1,1'b0,1'b0},
    {1'b1,3'd0,8'd253,1'b1,2'd3,1'b1,1'b0,1'b0},
    {1'b1,3'd0,8'd253,1'b1,2'd3,1'b1,1'b0,1'b0},
    {1'b1,3'd0,8'd253,1'b1,2'd3,1'b1,1'b0,1'b0},
    {1'b1,3'd0,8'd253,1'b1,2'd3,1'b1,1'b0,1'b0},
    {1'b1,3'd0,8'd253,1'b1,2'd3,1'b1,1'b0,1'b0},
    {1'b1,3'd0,8'd253,1'b1,2'd3,1'b1,1'b1,1'b0},
    {1'b1,3'd0,8'd253,1'b1,2'd3,1'b1,1'b0,1'b1},
    {1'b1,3'd0,8'd253,1'b1,2'd3,1'b1,1'b0,1'b0},
    {1'b0,3'd1,8'd1,  1'b1,2'd3,1'b1,1'b0,1'b0},
    {1'b0,3'd2,8'd254,1'b0,2'd3,1'b1,1'b0,1'b0}
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // strobe for one cycle, then wait so two rising edges have passed
  task automatic do_key(input logic [2:0] s);
    reg_sel = s; key_done = 1'b1;
    @(negedge clk); key_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_mid(input int n);
    for (int i = 0; i < n; i++) begin
      mid_fall = 1'b1; @(negedge clk);
    end
    mid_fall = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [15:0] snap();
    return {2'b0, mag_o, fpol_o, fall_o, opol_o, chk_lo_o, chk_hi_o};
  endfunction

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 in reset", {snap()[13:0], marg_o, 1'b0}, 16'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", {snap()[13:0], marg_o, 1'b0}, 16'h0);

    // vector table: R2/R3/R4/R5/R6/R7/R11 (trial values persist across selects)
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][17]) do_mid(1);
      else            do_key(VEC[v][16:14]);
      check($sformatf("R2/R3/R4/R5/R6/R7/R11 row %0d", v), snap(), {2'b0, VEC[v][13:0]});
    end

    // reset clears everything again (R1)
    rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
    check("R1 re-reset", snap(), 16'h0);

    // R11: mid with no selection, and reserved select value
    do_mid(1);
    check("R11 idle mid", snap(), 16'h0);
    do_key(3'd6); do_mid(3);
    check("R11 reserved select", snap(), 16'h0);

    // R3 wrap in positive up register
    do_key(3'd0); do_mid(254);
    check("R3 code 255", {8'h0, mag_o}, 16'd255);
    do_mid(1);
    check("R3 wrap to 0", {8'h0, mag_o}, 16'd0);

    // R4 down register ends
    do_key(3'd2);
    check("R4 code 1", {8'h0, mag_o}, 16'd254);
    do_mid(254);
    check("R4 code 255", {8'h0, mag_o}, 16'd0);
    do_mid(1);
    check("R4 code 0", {8'h0, mag_o}, 16'd255);

    // R8 blown fuses force ones, visible after one edge (R12)
    fuse_fpol = 1'b1; fuse_fall = 2'b10; fuse_opol = 1'b1;
    @(negedge clk);
    check("R8 R12 fuse fields", {12'h0, fpol_o, fall_o, opol_o}, 16'b1101);
    fuse_mag = 8'h80;
    do_key(3'd0);
    check("R8 magnitude merge", {8'h0, mag_o}, 16'h81);
    fuse_mag = '0; fuse_fpol = 1'b0; fuse_fall = '0; fuse_opol = 1'b0;
    @(negedge clk);
    check("R8 unblown passes trial", snap(), {2'b0, 8'd1, 1'b0, 2'd0, 1'b0, 2'b00});

    // R10 marginal flag
    fuse_marg = 13'h0004;
    do_key(3'd5); do_mid(7);
    check("R10 code 8", {13'h0, chk_lo_o, chk_hi_o, marg_o}, 16'b101);
    do_mid(1);
    check("R10 code 9", {13'h0, chk_lo_o, chk_hi_o, marg_o}, 16'b011);
    do_mid(1);
    check("R10 code 10", {13'h0, chk_lo_o, chk_hi_o, marg_o}, 16'b000);
    fuse_marg = '0;

    // R9 lock
    fuse_lock = 1'b1;
    do_key(3'd3); do_mid(2);
    check("R9 locked threshold", snap(), {2'b0, 8'd1, 1'b0, 2'd0, 1'b0, 2'b00});
    do_key(3'd4); do_mid(3);
    check("R9 locked output reg", snap(), {2'b0, 8'd1, 1'b0, 2'd0, 1'b0, 2'b00});
    do_key(3'd5); do_mid(7);
    check("R9 check reg after lock", {14'h0, chk_lo_o, chk_hi_o}, 16'b10);
    fuse_lock = 1'b0;

    // R12 strobe latency: old value after first edge, new after second
    reg_sel = 3'd1; key_done = 1'b1;
    @(negedge clk); key_done = 1'b0;
    check("R12 before second edge", {15'h0, fpol_o}, 16'd0);
    @(negedge clk);
    check("R12 after second edge", {15'h0, fpol_o}, 16'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule